// File: doc/BRIEF.md
# Linked-List Frame Descriptor Fetcher

This block walks a set of display DMA channels through chains of frame descriptors held in memory. Each channel owns a small register set: the pointer to its next descriptor, the frame source address, a frame tag and a command word. It also owns a one-shot branch register. When a frame starts, the block visits every channel that is switched on, in ascending order. For each one it picks a descriptor pointer, reads the four descriptor words through a single-outstanding memory read port and stores them in the channel's registers.

The pointer normally comes from the stored next-descriptor register. If the branch register is armed, the pointer comes from the branch register instead, and only for that one frame. An armed branch can also raise a branch event. Descriptor and source addresses are checked against a memory window that is set by parameters. A descriptor that lies outside the window is not read. A channel that ends the fetch with a zero or out-of-window source raises a bus-error event that carries its channel number. After the last channel has been handled, a single frame-done pulse marks the end of the walk.

Top module: `fdesc_fetch`

## Requirements
- R1: The per-channel slot for channel c starts at byte offset 0x200 + 16*c and holds the next-descriptor pointer at +0x0, the source at +0x4, the frame tag at +0x8 and the command at +0xC. Every register reads zero after reset. The read data is combinational.
- R2: A write to the next-descriptor slot stores the value with bits 3:0 cleared. Writes to the source, tag and command slots have no effect.
- R3: The branch register of channel c sits at offset 0x100 + 4*c. A write keeps bits 31:4, 1 and 0 and clears bits 3:2.
- R4: Channel enables are latched at frame start. Channel 0 follows `en_main`. Channel 1 follows `en_ovl1` OR `en_dual_scan`. Channels 2 to 4 follow `en_ovl2`. Channel 5 follows `en_cursor`. Channel 6 is never enabled. A disabled channel issues no memory reads.
- R5: An accepted frame start clears the source register of every channel, whether or not the channel is enabled.
- R6: If branch bit 0 is set when a channel is picked, the pointer is branch bits 31:4 followed by four zero bits. Branch bit 0 then reads back as zero. If branch bit 1 is also set, `bs_evt` pulses for one cycle with `bs_ch` equal to the channel.
- R7: If branch bit 0 is clear, the stored next-descriptor pointer is used. Branch bit 1 alone raises no event.
- R8: A descriptor fetch reads the addresses p, p+4, p+8 and p+12, in that order. The words go to the next pointer, the source, the tag and the command respectively.
- R9: If a descriptor pointer p has p < WIN_BASE or p+16 > WIN_BASE+WIN_SIZE, the descriptor is skipped. No memory read is made and the source stays zero.
- R10: After its fetch step, an enabled channel whose source is zero, or lies outside [WIN_BASE, WIN_BASE+WIN_SIZE], pulses `ber_evt` with `ber_ch` equal to the channel.
- R11: Channels are served in ascending order with one read outstanding. `mem_req` stays high with a stable `mem_addr` until `mem_ack`.
- R12: `frame_done` pulses for exactly one cycle after the last channel has been handled. A frame start that arrives during a walk is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Starts a descriptor walk when the block is idle |
| en_main | input | 1 | Base plane enable (channel 0) |
| en_ovl1 | input | 1 | First overlay enable (channel 1) |
| en_dual_scan | input | 1 | Dual-scan mode, also enables channel 1 |
| en_ovl2 | input | 1 | Second overlay enable (channels 2 to 4) |
| en_cursor | input | 1 | Cursor plane enable (channel 5) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_ack | input | 1 | Read data valid, ends the request |
| mem_rdata | input | AW | Read data |
| bs_evt | output | 1 | Branch event pulse |
| bs_ch | output | $clog2(NCH) | Channel of the branch event |
| ber_evt | output | 1 | Bus error event pulse |
| ber_ch | output | $clog2(NCH) | Channel of the bus error |
| frame_done | output | 1 | Walk finished pulse |

## Verification
Register writes show up on `reg_rdata` in the cycle after the write edge, so the bench reads each one back at a later falling edge. The branch and bus-error pulses come one cycle after the step that decides them, and `frame_done` comes one cycle after the last channel step. Because of this, a falling-edge monitor counts and logs every pulse and every accepted read over the whole walk, and the bench compares those logs and the channel registers only after `frame_done` has been seen. The memory model answers one cycle after a request, so the bench also checks the read order from the logged addresses rather than from fixed cycle numbers.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
  localparam int unsigned REG_AW = 12;
  localparam logic [1:0] WRD_NEXT = 2'd0;
  localparam logic [1:0] WRD_SRC  = 2'd1;
  localparam logic [1:0] WRD_TAG  = 2'd2;
  localparam logic [1:0] WRD_CMD  = 2'd3;
  typedef enum logic [1:0] {ST_IDLE, ST_PICK, ST_LOAD, ST_CHECK} seq_state_e;
endpackage

// File: rtl/fdf_chan_bank.sv
module fdf_chan_bank
  import fdf_pkg::*;
#(
  parameter int NCH = 7,
  parameter int AW  = 32,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [REG_AW-1:0]        reg_addr,
  input  logic [AW-1:0]            reg_wdata,
  output logic [AW-1:0]            reg_rdata,
  input  logic                     load_en,
  input  logic [CHW-1:0]           load_ch,
  input  logic [1:0]               load_word,
  input  logic [AW-1:0]            load_data,
  input  logic                     clr_src,
  input  logic                     brn_clr,
  input  logic [CHW-1:0]           brn_clr_ch,
  output logic [NCH-1:0][AW-1:0]   nxt_o,
  output logic [NCH-1:0][AW-1:0]   src_o,
  output logic [NCH-1:0][AW-1:0]   brn_o
);
  localparam logic [AW-1:0] NXT_MASK = ~AW'(15);
  localparam logic [AW-1:0] BRN_MASK = ~AW'(12);

  logic [NCH-1:0][AW-1:0] nxt_q, src_q, tag_q, cmd_q, brn_q;

  logic [3:0]     slot_raw, brn_raw;
  logic           slot_sel, brn_sel;
  logic [CHW-1:0] slot_ch, brn_ch;

  assign slot_raw = reg_addr[7:4];
  assign brn_raw  = reg_addr[5:2];
  assign slot_sel = (reg_addr[11:8] == 4'h2) && (reg_addr[1:0] == 2'b00) && (int'(slot_raw) < NCH);
  assign brn_sel  = (reg_addr[11:8] == 4'h1) && (reg_addr[7:6] == 2'b00) &&
                    (reg_addr[1:0] == 2'b00) && (int'(brn_raw) < NCH);
  assign slot_ch  = slot_raw[CHW-1:0];
  assign brn_ch   = brn_raw[CHW-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic ld_hit, wr_nxt, wr_brn, clr_brn;
    assign ld_hit  = load_en && (load_ch == CHW'(c));
    assign wr_nxt  = reg_we && slot_sel && (slot_ch == CHW'(c)) && (reg_addr[3:2] == WRD_NEXT);
    assign wr_brn  = reg_we && brn_sel && (brn_ch == CHW'(c));
    assign clr_brn = brn_clr && (brn_clr_ch == CHW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        nxt_q[c] <= '0;
        src_q[c] <= '0;
        tag_q[c] <= '0;
        cmd_q[c] <= '0;
        brn_q[c] <= '0;
      end else begin
        if (ld_hit && load_word == WRD_NEXT) nxt_q[c] <= load_data;
        else if (wr_nxt)                     nxt_q[c] <= reg_wdata & NXT_MASK;
        if (clr_src)                         src_q[c] <= '0;
        else if (ld_hit && load_word == WRD_SRC) src_q[c] <= load_data;
        if (ld_hit && load_word == WRD_TAG)  tag_q[c] <= load_data;
        if (ld_hit && load_word == WRD_CMD)  cmd_q[c] <= load_data;
        if (clr_brn)                         brn_q[c] <= brn_q[c] & ~AW'(1);
        else if (wr_brn)                     brn_q[c] <= reg_wdata & BRN_MASK;
      end
    end

    // Armed branch is consumed by the pick step
    assert_branch_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_brn |=> !brn_q[c][0]);
  end

  always_comb begin
    reg_rdata = '0;
    if (slot_sel) begin
      case (reg_addr[3:2])
        WRD_NEXT: reg_rdata = nxt_q[slot_ch];
        WRD_SRC:  reg_rdata = src_q[slot_ch];
        WRD_TAG:  reg_rdata = tag_q[slot_ch];
        default:  reg_rdata = cmd_q[slot_ch];
      endcase
    end else if (brn_sel) begin
      reg_rdata = brn_q[brn_ch];
    end
  end

  assign nxt_o = nxt_q;
  assign src_o = src_q;
  assign brn_o = brn_q;

  assert_src_readonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !clr_src) |=> $stable(src_q));
  assert_src_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_src |=> (src_q == '0));
endmodule

// File: rtl/fdf_walk_seq.sv
module fdf_walk_seq
  import fdf_pkg::*;
#(
  parameter int NCH = 7,
  parameter int AW  = 32,
  parameter logic [AW-1:0] WIN_BASE = 'h1000,
  parameter logic [AW-1:0] WIN_SIZE = 'h100,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_start,
  input  logic [NCH-1:0]          en_vec,
  input  logic [NCH-1:0][AW-1:0]  nxt_i,
  input  logic [NCH-1:0][AW-1:0]  src_i,
  input  logic [NCH-1:0][AW-1:0]  brn_i,
  output logic                    mem_req,
  output logic [AW-1:0]           mem_addr,
  input  logic                    mem_ack,
  input  logic [AW-1:0]           mem_rdata,
  output logic                    load_en,
  output logic [CHW-1:0]          load_ch,
  output logic [1:0]              load_word,
  output logic [AW-1:0]           load_data,
  output logic                    clr_src,
  output logic                    brn_clr,
  output logic                    bs_evt,
  output logic [CHW-1:0]          bs_ch,
  output logic                    ber_evt,
  output logic [CHW-1:0]          ber_ch,
  output logic                    frame_done
);
  localparam int CNTW = $clog2(NCH + 1);
  localparam logic [AW:0] WIN_LO = {1'b0, WIN_BASE};
  localparam logic [AW:0] WIN_HI = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};

  seq_state_e      state_q, state_d;
  logic [CNTW-1:0] ch_q, ch_d;
  logic [1:0]      widx_q, widx_d;
  logic [AW-1:0]   ptr_q, ptr_d;
  logic [NCH-1:0]  en_q, en_d;
  logic            bs_d, ber_d, done_d;
  logic [CHW-1:0]  ch_idx;
  logic [AW-1:0]   cur_nxt, cur_src, cur_brn;
  logic            at_end;

  function automatic logic desc_in_win(input logic [AW-1:0] p);
    return ({1'b0, p} >= WIN_LO) && (({1'b0, p} + (AW+1)'(16)) <= WIN_HI);
  endfunction

  function automatic logic src_in_win(input logic [AW-1:0] s);
    return (s != '0) && ({1'b0, s} >= WIN_LO) && ({1'b0, s} <= WIN_HI);
  endfunction

  assign at_end  = (ch_q == CNTW'(NCH));
  assign ch_idx  = ch_q[CHW-1:0];
  assign cur_nxt = nxt_i[ch_idx];
  assign cur_src = src_i[ch_idx];
  assign cur_brn = brn_i[ch_idx];

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    widx_d  = widx_q;
    ptr_d   = ptr_q;
    en_d    = en_q;
    clr_src = 1'b0;
    brn_clr = 1'b0;
    load_en = 1'b0;
    bs_d    = 1'b0;
    ber_d   = 1'b0;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: if (frame_start) begin
        clr_src = 1'b1;
        en_d    = en_vec;
        ch_d    = '0;
        state_d = ST_PICK;
      end
      ST_PICK: begin
        if (at_end) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (!en_q[ch_idx]) begin
          ch_d = ch_q + 1'b1;
        end else begin
          if (cur_brn[0]) begin
            ptr_d   = cur_brn & ~AW'(15);
            brn_clr = 1'b1;
            bs_d    = cur_brn[1];
          end else begin
            ptr_d = cur_nxt;
          end
          widx_d  = '0;
          state_d = desc_in_win(ptr_d) ? ST_LOAD : ST_CHECK;
        end
      end
      ST_LOAD: if (mem_ack) begin
        load_en = 1'b1;
        widx_d  = widx_q + 1'b1;
        if (widx_q == WRD_CMD) state_d = ST_CHECK;
      end
      default: begin
        ber_d   = !src_in_win(cur_src);
        ch_d    = ch_q + 1'b1;
        state_d = ST_PICK;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ch_q       <= '0;
      widx_q     <= '0;
      ptr_q      <= '0;
      en_q       <= '0;
      bs_evt     <= 1'b0;
      bs_ch      <= '0;
      ber_evt    <= 1'b0;
      ber_ch     <= '0;
      frame_done <= 1'b0;
    end else begin
      state_q    <= state_d;
      ch_q       <= ch_d;
      widx_q     <= widx_d;
      ptr_q      <= ptr_d;
      en_q       <= en_d;
      bs_evt     <= bs_d;
      ber_evt    <= ber_d;
      frame_done <= done_d;
      if (bs_d)  bs_ch  <= ch_idx;
      if (ber_d) ber_ch <= ch_idx;
    end
  end

  assign mem_req   = (state_q == ST_LOAD);
  assign mem_addr  = ptr_q + {{(AW-4){1'b0}}, widx_q, 2'b00};
  assign load_ch   = ch_idx;
  assign load_word = widx_q;
  assign load_data = mem_rdata;

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  assert_req_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (({1'b0, mem_addr} >= WIN_LO) && (({1'b0, mem_addr} + (AW+1)'(4)) <= WIN_HI)));
  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

// File: rtl/fdesc_fetch.sv
module fdesc_fetch
  import fdf_pkg::*;
#(
  parameter int NCH = 7,
  parameter int AW  = 32,
  parameter logic [AW-1:0] WIN_BASE = 'h1000,
  parameter logic [AW-1:0] WIN_SIZE = 'h100
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_start,
  input  logic                     en_main,
  input  logic                     en_ovl1,
  input  logic                     en_dual_scan,
  input  logic                     en_ovl2,
  input  logic                     en_cursor,
  input  logic                     reg_we,
  input  logic [REG_AW-1:0]        reg_addr,
  input  logic [AW-1:0]            reg_wdata,
  output logic [AW-1:0]            reg_rdata,
  output logic                     mem_req,
  output logic [AW-1:0]            mem_addr,
  input  logic                     mem_ack,
  input  logic [AW-1:0]            mem_rdata,
  output logic                     bs_evt,
  output logic [$clog2(NCH)-1:0]   bs_ch,
  output logic                     ber_evt,
  output logic [$clog2(NCH)-1:0]   ber_ch,
  output logic                     frame_done
);
  localparam int CHW = $clog2(NCH);

  logic [NCH-1:0]         en_vec;
  logic [NCH-1:0][AW-1:0] nxt_w, src_w, brn_w;
  logic                   load_en, clr_src, brn_clr;
  logic [CHW-1:0]         load_ch;
  logic [1:0]             load_word;
  logic [AW-1:0]          load_data;

  always_comb begin
    en_vec = '0;
    for (int c = 0; c < NCH; c++) begin
      case (c)
        0:       en_vec[c] = en_main;
        1:       en_vec[c] = en_ovl1 | en_dual_scan;
        2, 3, 4: en_vec[c] = en_ovl2;
        5:       en_vec[c] = en_cursor;
        default: en_vec[c] = 1'b0;
      endcase
    end
  end

  fdf_chan_bank #(.NCH(NCH), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .load_en(load_en), .load_ch(load_ch), .load_word(load_word), .load_data(load_data),
    .clr_src(clr_src), .brn_clr(brn_clr), .brn_clr_ch(load_ch),
    .nxt_o(nxt_w), .src_o(src_w), .brn_o(brn_w)
  );

  fdf_walk_seq #(.NCH(NCH), .AW(AW), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .en_vec(en_vec),
    .nxt_i(nxt_w), .src_i(src_w), .brn_i(brn_w),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .load_en(load_en), .load_ch(load_ch), .load_word(load_word), .load_data(load_data),
    .clr_src(clr_src), .brn_clr(brn_clr),
    .bs_evt(bs_evt), .bs_ch(bs_ch), .ber_evt(ber_evt), .ber_ch(ber_ch),
    .frame_done(frame_done)
  );
endmodule

// File: tb/fdesc_fetch_tb_top.sv
`timescale 1ns/1ps
module fdesc_fetch_tb_top;
  localparam logic [31:0] BASE = 32'h1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        en_main = 1'b0, en_ovl1 = 1'b0, en_dual_scan = 1'b0, en_ovl2 = 1'b0, en_cursor = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        bs_evt, ber_evt, frame_done;
  logic [2:0]  bs_ch, ber_ch;

  always #2 clk = ~clk;

  fdesc_fetch dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .en_main(en_main), .en_ovl1(en_ovl1), .en_dual_scan(en_dual_scan),
    .en_ovl2(en_ovl2), .en_cursor(en_cursor),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .bs_evt(bs_evt), .bs_ch(bs_ch), .ber_evt(ber_evt), .ber_ch(ber_ch),
    .frame_done(frame_done)
  );

  logic [31:0] mem [64];
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[6'((mem_addr - BASE) >> 2)];
    end else begin
      mem_ack <= 1'b0;
    end
  end

  int ber_cnt = 0, bs_cnt = 0, done_cnt = 0, rd_cnt = 0;
  logic [2:0]  ber_log [8];
  logic [2:0]  bs_log  [8];
  logic [31:0] rd_log  [32];
  always @(negedge clk) if (rst_n) begin
    if (ber_evt) begin if (ber_cnt < 8) ber_log[ber_cnt] = ber_ch; ber_cnt++; end
    if (bs_evt)  begin if (bs_cnt < 8)  bs_log[bs_cnt]   = bs_ch;  bs_cnt++;  end
    if (frame_done) done_cnt++;
    if (mem_req && mem_ack) begin if (rd_cnt < 32) rd_log[rd_cnt] = mem_addr; rd_cnt++; end
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic run_frame();
    int start;
    ber_cnt = 0; bs_cnt = 0; rd_cnt = 0;
    start = done_cnt;
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    for (int i = 0; i < 400 && done_cnt == start; i++) @(negedge clk);
    if (done_cnt == start) chk("R12 frame_done seen", 32'd0, 32'd1);
    @(negedge clk);
  endtask

  function automatic logic [11:0] slot(input int ch, input int w);
    return 12'(32'h200 + 16 * ch + 4 * w);
  endfunction

  typedef struct packed {
    logic [31:0] nxt;
    logic [31:0] br;
    logic [31:0] src;
    logic        ber;
    logic        bs;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{32'h1000, 32'h0,    32'h1080, 1'b0, 1'b0},  // R7 plain chain, R10 good source
    '{32'h1010, 32'h0,    32'h0,    1'b1, 1'b0},  // R10 zero source
    '{32'h1020, 32'h0,    32'h2000, 1'b1, 1'b0},  // R10 source beyond window
    '{32'h1030, 32'h0,    32'h1100, 1'b0, 1'b0},  // R10 source at window top
    '{32'h10F0, 32'h0,    32'h1004, 1'b0, 1'b0},  // R9 last fitting descriptor
    '{32'h1100, 32'h0,    32'h0,    1'b1, 1'b0},  // R9 descriptor past window
    '{32'h0FF0, 32'h0,    32'h0,    1'b1, 1'b0},  // R9 descriptor below window
    '{32'h1000, 32'h1031, 32'h1100, 1'b0, 1'b0},  // R6 branch, no event
    '{32'h1000, 32'h1033, 32'h1100, 1'b0, 1'b1},  // R6 branch with event
    '{32'h1000, 32'h1012, 32'h1080, 1'b0, 1'b0}   // R7 unarmed branch ignored
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[0]  = 32'h1010; mem[1]  = 32'h1080; mem[2]  = 32'hA1; mem[3]  = 32'h0060_0100;
    mem[4]  = 32'h1000; mem[5]  = 32'h0;    mem[6]  = 32'hB2; mem[7]  = 32'h0;
    mem[8]  = 32'h1020; mem[9]  = 32'h2000; mem[10] = 32'hC3; mem[11] = 32'h0;
    mem[12] = 32'h1000; mem[13] = 32'h1100; mem[14] = 32'hD4; mem[15] = 32'h0;
    mem[60] = 32'h1000; mem[61] = 32'h1004; mem[62] = 32'hE5; mem[63] = 32'h0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(slot(0, 0), d); chk("R1 reset next ch0", d, 32'h0);
    rd(slot(6, 3), d); chk("R1 reset cmd ch6", d, 32'h0);
    rd(12'h118, d);    chk("R1 reset branch ch6", d, 32'h0);
    chk("R12 reset frame_done", {31'b0, frame_done}, 32'h0);
    chk("R11 reset mem_req", {31'b0, mem_req}, 32'h0);

    // R2 alignment and read-only slots
    wr(slot(3, 0), 32'h1237);
    rd(slot(3, 0), d); chk("R2 next aligned", d, 32'h1230);
    wr(slot(3, 1), 32'hDEAD);
    rd(slot(3, 1), d); chk("R2 source ignores write", d, 32'h0);
    wr(slot(3, 2), 32'hBEEF);
    rd(slot(3, 2), d); chk("R2 tag ignores write", d, 32'h0);
    // R3 branch mask
    wr(12'h10C, 32'hFFFF_FFFF);
    rd(12'h10C, d); chk("R3 branch mask", d, 32'hFFFF_FFF3);
    wr(12'h10C, 32'h0);

    // R8 word order and loading
    en_main = 1'b1;
    wr(slot(0, 0), 32'h1000);
    run_frame();
    chk("R8 read count", rd_cnt, 4);
    for (int k = 0; k < 4; k++) chk("R8 read address", rd_log[k], BASE + 32'(4 * k));
    rd(slot(0, 0), d); chk("R8 next loaded", d, 32'h1010);
    rd(slot(0, 2), d); chk("R8 tag loaded", d, 32'hA1);
    rd(slot(0, 3), d); chk("R8 command loaded", d, 32'h0060_0100);

    // Vector table on channel 0
    for (int v = 0; v < 10; v++) begin
      wr(slot(0, 0), VEC[v].nxt);
      wr(12'h100, VEC[v].br);
      run_frame();
      rd(slot(0, 1), d); chk("R6 R7 R9 R10 source", d, VEC[v].src);
      chk("R10 bus error count", ber_cnt, {31'b0, VEC[v].ber});
      chk("R6 branch event count", bs_cnt, {31'b0, VEC[v].bs});
      rd(12'h100, d); chk("R6 branch bit0 consumed", d, VEC[v].br & ~32'h1);
      if (VEC[v].nxt == 32'h1100 || VEC[v].nxt == 32'h0FF0)
        chk("R9 no memory read", rd_cnt, 0);
    end
    chk("R6 bs_ch tag", {29'b0, bs_log[0]}, 32'h0);

    // R4 R5 enable mapping
    for (int m = 0; m < 5; m++) begin
      logic [6:0] exp_mask;
      for (int c = 0; c < 7; c++) wr(slot(c, 0), 32'h1000);
      en_main = (m == 0); en_ovl1 = (m == 1); en_dual_scan = (m == 2);
      en_ovl2 = (m == 3); en_cursor = (m == 4);
      case (m)
        0: exp_mask = 7'b0000001;
        1, 2: exp_mask = 7'b0000010;
        3: exp_mask = 7'b0011100;
        default: exp_mask = 7'b0100000;
      endcase
      run_frame();
      for (int c = 0; c < 7; c++) begin
        rd(slot(c, 1), d);
        chk("R4 R5 source per channel", d, exp_mask[c] ? 32'h1080 : 32'h0);
      end
      chk("R4 reads per frame", rd_cnt, 4 * $countones(exp_mask));
    end

    // R11 ascending order, R10 channel tags
    en_main = 1'b0; en_ovl1 = 1'b0; en_dual_scan = 1'b0; en_cursor = 1'b0; en_ovl2 = 1'b1;
    for (int c = 0; c < 7; c++) wr(slot(c, 0), 32'h1010);
    run_frame();
    chk("R10 error count ch2-ch4", ber_cnt, 3);
    for (int k = 0; k < 3; k++) chk("R11 ascending ber_ch", {29'b0, ber_log[k]}, 32'(k + 2));

    // R12 start during a walk is ignored
    en_ovl2 = 1'b0; en_main = 1'b1;
    wr(slot(0, 0), 32'h1000);
    ber_cnt = 0; bs_cnt = 0; rd_cnt = 0;
    begin
      int start;
      start = done_cnt;
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); @(negedge clk); @(negedge clk);
      frame_start = 1'b0;
      repeat (60) @(negedge clk);
      chk("R12 single frame_done", done_cnt - start, 1);
      chk("R12 single fetch", rd_cnt, 4);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule